// File: doc/BRIEF.md
# GPIO Port Pair with Peripheral Pin Overrides

This block controls two 8-bit bidirectional pin ports. Each pin has a direction bit and a latch bit in software-visible registers. Peripherals can take over any pin's pull-up, output enable and driven value. Each of these three attributes has its own enable/value pair and is chosen independently of the other two. Port A is the multiplexed address/data bus of an external memory interface. Port B carries the four serial-peripheral pins, and the serial master/slave role decides which of them are forced to be inputs.

Software writes and reads the latch and direction registers through a small register interface. It reads the pin levels through a two-stage synchronizer. The serial shifter and the memory bus sequencer are outside this block. Their strobes and data arrive as plain inputs. All pad controls leave the block from flip-flops.

Top module: `gpio_altfunc_port`

## Requirements
- R1: Register access uses `reg_addr[2]` to select the port (0 = A, 1 = B) and `reg_addr[1:0]` to select the field: 0 = latch, 1 = direction, 2 = synchronized pin level (read-only, writes ignored), 3 = reads zero. `reg_rdata` is registered and shows the addressed field one cycle after the address. Reset clears all registers, `reg_rdata` and every pad output.
- R2: A pin with no override and a direction bit of 1 is driven with its latch bit. With a direction bit of 0, its pull-up equals its latch bit. No pin ever has output enable and pull-up active together.
- R3: Port B bit 7 is the serial clock. When serial is enabled as slave, the pin is an input whatever its direction bit holds. As master, its direction follows the register, and its driven value is `spi_sck_o`.
- R4: Port B bit 6 is the master-in/slave-out pin. When serial is enabled as master, the pin is an input. As slave, its direction follows the register, and its driven value is `spi_miso_o`.
- R5: Port B bits 5 (master-out) and 4 (select) are forced to input when serial is enabled as slave. As master, their direction follows the register. Bit 5 then drives `spi_mosi_o`, and bit 4 drives its latch bit.
- R6: Whenever serial forces a port B pin to input, that pin's pull-up equals its latch bit, even if its direction bit is 1.
- R7: With serial disabled, and on port B bits 3..0, port B behaves as in R2.
- R8: With `xmem_en` = 1, every port A pin is an output exactly when `xmem_wr` or `xmem_ale` is 1.
- R9: With `xmem_en` = 1, port A drives `xmem_addr` while `xmem_ale` = 1. Otherwise it drives `xmem_wdata` while `xmem_wr` = 1, and drives 0 when neither strobe is active.
- R10: With `xmem_en` = 1, the port A pull-up is the latch bit while neither strobe is active, and 0 while either strobe is active. With `xmem_en` = 0, port A behaves as in R2.
- R11: A pin level appears on `reg_rdata` three clock edges after it is applied: two synchronizer stages, then the read register. This holds even while a peripheral drives the pin.
- R12: A pad output changes on the first clock edge after an override input changes, and on the second clock edge after a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Port select and field select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pad levels |
| pa_out | output | 8 | Port A driven values |
| pa_oe | output | 8 | Port A output enables |
| pa_pu | output | 8 | Port A pull-up enables |
| pb_in | input | 8 | Port B pad levels |
| pb_out | output | 8 | Port B driven values |
| pb_oe | output | 8 | Port B output enables |
| pb_pu | output | 8 | Port B pull-up enables |
| spi_en | input | 1 | Serial peripheral enabled |
| spi_master | input | 1 | Serial role: 1 = master, 0 = slave |
| spi_sck_o | input | 1 | Serial clock value for master role |
| spi_miso_o | input | 1 | Serial data out for slave role |
| spi_mosi_o | input | 1 | Serial data out for master role |
| xmem_en | input | 1 | External memory interface owns port A |
| xmem_wr | input | 1 | Memory write strobe |
| xmem_ale | input | 1 | Memory address phase strobe |
| xmem_addr | input | 8 | Address byte for the address phase |
| xmem_wdata | input | 8 | Write data byte |

## Verification
Two functions can act on the same pin in the same cycle. The first is reading a pin level back through the synchronizer while the memory bus is driving that pin in a write phase. The second is forcing a pin to input while its latch and direction bits say something else. The bench holds `xmem_wr` high and steps `pa_in`. It then checks that `reg_rdata` keeps its old value after two edges and shows the new level after the third. All 32 combinations of serial enable, role, memory enable, write strobe and address strobe are applied under two opposite register settings. Every pad output is compared with values computed from the requirements.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  parameter int PIN_W = 8;

  typedef logic [PIN_W-1:0] pins_t;

  // one enable/value pair per pad attribute
  typedef struct packed {
    pins_t pu_en;
    pins_t pu_val;
    pins_t dir_en;
    pins_t dir_val;
    pins_t out_en;
    pins_t out_val;
  } pin_ovr_t;

  typedef enum logic [1:0] {
    SEL_LATCH = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_PIN   = 2'd2,
    SEL_NONE  = 2'd3
  } fld_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_spi_ovr.sv
module gpio_spi_ovr
  import gpio_ovr_pkg::*;
#(
  parameter int SCK_BIT  = 7,
  parameter int MISO_BIT = 6,
  parameter int MOSI_BIT = 5,
  parameter int SS_BIT   = 4
) (
  input  logic     spi_en,
  input  logic     spi_master,
  input  logic     sck_o,
  input  logic     miso_o,
  input  logic     mosi_o,
  input  pins_t    latch_q,
  output pin_ovr_t ovr
);
  logic mst, slv;
  assign mst = spi_en & spi_master;
  assign slv = spi_en & ~spi_master;

  always_comb begin
    ovr        = '0;
    // a forced input keeps its pull-up under control of the latch bit
    ovr.pu_val = latch_q;
    // clock: input as slave, driven by the shifter as master
    ovr.dir_en[SCK_BIT]  = slv;
    ovr.pu_en[SCK_BIT]   = slv;
    ovr.out_en[SCK_BIT]  = mst;
    ovr.out_val[SCK_BIT] = sck_o;
    // master-in/slave-out: input as master, driven as slave
    ovr.dir_en[MISO_BIT]  = mst;
    ovr.pu_en[MISO_BIT]   = mst;
    ovr.out_en[MISO_BIT]  = slv;
    ovr.out_val[MISO_BIT] = miso_o;
    // master-out: input as slave, driven as master
    ovr.dir_en[MOSI_BIT]  = slv;
    ovr.pu_en[MOSI_BIT]   = slv;
    ovr.out_en[MOSI_BIT]  = mst;
    ovr.out_val[MOSI_BIT] = mosi_o;
    // select: input as slave, plain port as master
    ovr.dir_en[SS_BIT] = slv;
    ovr.pu_en[SS_BIT]  = slv;
  end
endmodule

// File: rtl/gpio_xmem_ovr.sv
module gpio_xmem_ovr
  import gpio_ovr_pkg::*;
(
  input  logic     xmem_en,
  input  logic     wr,
  input  logic     ale,
  input  pins_t    addr,
  input  pins_t    wdata,
  input  pins_t    latch_q,
  output pin_ovr_t ovr
);
  logic drive;
  assign drive = wr | ale;

  always_comb begin
    ovr.pu_en   = {PIN_W{xmem_en}};
    ovr.dir_en  = {PIN_W{xmem_en}};
    ovr.out_en  = {PIN_W{xmem_en}};
    ovr.dir_val = {PIN_W{drive}};
    ovr.pu_val  = latch_q & ~{PIN_W{drive}};
    if (ale)     ovr.out_val = addr;
    else if (wr) ovr.out_val = wdata;
    else         ovr.out_val = '0;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_ovr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_latch,
  input  logic     wr_dir,
  input  pins_t    wdata,
  input  pin_ovr_t ovr,
  input  pins_t    pad_in,
  output pins_t    latch_q,
  output pins_t    dir_q,
  output pins_t    pin_q,
  output pins_t    pad_out,
  output pins_t    pad_oe,
  output pins_t    pad_pu
);
  pins_t oe_n, out_n, pu_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (wr_latch) latch_q <= wdata;
      if (wr_dir)   dir_q   <= wdata;
    end
  end

  gpio_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pin_q)
  );

  // per-pin choice between peripheral value and register-derived value
  for (genvar b = 0; b < PIN_W; b++) begin : g_pin
    assign oe_n[b]  = ovr.dir_en[b] ? ovr.dir_val[b] : dir_q[b];
    assign out_n[b] = ovr.out_en[b] ? ovr.out_val[b] : latch_q[b];
    assign pu_n[b]  = ovr.pu_en[b]  ? ovr.pu_val[b]  : (~dir_q[b] & latch_q[b]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= '0;
      pad_out <= '0;
      pad_pu  <= '0;
    end else begin
      pad_oe  <= oe_n;
      pad_out <= out_n;
      pad_pu  <= pu_n;
    end
  end

  assert_no_drive_with_pull_R2: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & pad_pu) == '0);
endmodule

// File: rtl/gpio_altfunc_port.sv
module gpio_altfunc_port
  import gpio_ovr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SCK_BIT     = 7,
  parameter int MISO_BIT    = 6,
  parameter int MOSI_BIT    = 5,
  parameter int SS_BIT      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [PIN_W-1:0] reg_wdata,
  output logic [PIN_W-1:0] reg_rdata,
  input  logic [PIN_W-1:0] pa_in,
  output logic [PIN_W-1:0] pa_out,
  output logic [PIN_W-1:0] pa_oe,
  output logic [PIN_W-1:0] pa_pu,
  input  logic [PIN_W-1:0] pb_in,
  output logic [PIN_W-1:0] pb_out,
  output logic [PIN_W-1:0] pb_oe,
  output logic [PIN_W-1:0] pb_pu,
  input  logic             spi_en,
  input  logic             spi_master,
  input  logic             spi_sck_o,
  input  logic             spi_miso_o,
  input  logic             spi_mosi_o,
  input  logic             xmem_en,
  input  logic             xmem_wr,
  input  logic             xmem_ale,
  input  logic [PIN_W-1:0] xmem_addr,
  input  logic [PIN_W-1:0] xmem_wdata
);
  pins_t    a_latch, a_dir, a_pin, b_latch, b_dir, b_pin;
  pin_ovr_t a_ovr, b_ovr;
  logic     sel_b;
  fld_e     fld;

  assign sel_b = reg_addr[2];
  assign fld   = fld_e'(reg_addr[1:0]);

  gpio_xmem_ovr u_xmem (
    .xmem_en (xmem_en),
    .wr      (xmem_wr),
    .ale     (xmem_ale),
    .addr    (xmem_addr),
    .wdata   (xmem_wdata),
    .latch_q (a_latch),
    .ovr     (a_ovr)
  );

  gpio_spi_ovr #(
    .SCK_BIT (SCK_BIT), .MISO_BIT (MISO_BIT),
    .MOSI_BIT(MOSI_BIT), .SS_BIT (SS_BIT)
  ) u_spi (
    .spi_en     (spi_en),
    .spi_master (spi_master),
    .sck_o      (spi_sck_o),
    .miso_o     (spi_miso_o),
    .mosi_o     (spi_mosi_o),
    .latch_q    (b_latch),
    .ovr        (b_ovr)
  );

  gpio_port #(.SYNC_STAGES(SYNC_STAGES)) u_port_a (
    .clk      (clk),
    .rst      (rst),
    .wr_latch (reg_we && !sel_b && fld == SEL_LATCH),
    .wr_dir   (reg_we && !sel_b && fld == SEL_DIR),
    .wdata    (reg_wdata),
    .ovr      (a_ovr),
    .pad_in   (pa_in),
    .latch_q  (a_latch),
    .dir_q    (a_dir),
    .pin_q    (a_pin),
    .pad_out  (pa_out),
    .pad_oe   (pa_oe),
    .pad_pu   (pa_pu)
  );

  gpio_port #(.SYNC_STAGES(SYNC_STAGES)) u_port_b (
    .clk      (clk),
    .rst      (rst),
    .wr_latch (reg_we && sel_b && fld == SEL_LATCH),
    .wr_dir   (reg_we && sel_b && fld == SEL_DIR),
    .wdata    (reg_wdata),
    .ovr      (b_ovr),
    .pad_in   (pb_in),
    .latch_q  (b_latch),
    .dir_q    (b_dir),
    .pin_q    (b_pin),
    .pad_out  (pb_out),
    .pad_oe   (pb_oe),
    .pad_pu   (pb_pu)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (fld)
        SEL_LATCH: reg_rdata <= sel_b ? b_latch : a_latch;
        SEL_DIR:   reg_rdata <= sel_b ? b_dir   : a_dir;
        SEL_PIN:   reg_rdata <= sel_b ? b_pin   : a_pin;
        default:   reg_rdata <= '0;
      endcase
    end
  end

  assert_sck_slave_input_R3: assert property (@(posedge clk) disable iff (rst)
    (spi_en && !spi_master) |=> !pb_oe[SCK_BIT]);

  assert_miso_master_input_R4: assert property (@(posedge clk) disable iff (rst)
    (spi_en && spi_master) |=> !pb_oe[MISO_BIT]);

  assert_forced_pull_follows_latch_R6: assert property (@(posedge clk) disable iff (rst)
    (spi_en && !spi_master) |=> pb_pu[SCK_BIT] == $past(b_latch[SCK_BIT]));

  assert_bus_direction_R8: assert property (@(posedge clk) disable iff (rst)
    xmem_en |=> pa_oe == {PIN_W{$past(xmem_wr || xmem_ale)}});

  assert_addr_phase_value_R9: assert property (@(posedge clk) disable iff (rst)
    (xmem_en && xmem_ale) |=> pa_out == $past(xmem_addr));
endmodule

// File: tb/gpio_altfunc_port_bench.sv
module gpio_altfunc_port_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [7:0] pa_in = 8'd0, pb_in = 8'd0;
  logic [7:0] pa_out, pa_oe, pa_pu, pb_out, pb_oe, pb_pu;
  logic       spi_en = 0, spi_master = 0, spi_sck_o = 0, spi_miso_o = 0, spi_mosi_o = 0;
  logic       xmem_en = 0, xmem_wr = 0, xmem_ale = 0;
  logic [7:0] xmem_addr = 8'd0, xmem_wdata = 8'd0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [2:0] A_LATCH = 3'd0, A_DIR = 3'd1, A_PIN = 3'd2, A_NONE = 3'd3;
  localparam logic [2:0] B_LATCH = 3'd4, B_DIR = 3'd5, B_PIN = 3'd6;

  always #5 clk = ~clk;

  gpio_altfunc_port u_gpio_altfunc_port (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pa_pu(pa_pu),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pb_pu(pb_pu),
    .spi_en(spi_en), .spi_master(spi_master), .spi_sck_o(spi_sck_o),
    .spi_miso_o(spi_miso_o), .spi_mosi_o(spi_mosi_o),
    .xmem_en(xmem_en), .xmem_wr(xmem_wr), .xmem_ale(xmem_ale),
    .xmem_addr(xmem_addr), .xmem_wdata(xmem_wdata)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // R1: reset state and register map
  task automatic t_reset_regs();
    logic [7:0] d;
    check("R1 reset pa_oe", pa_oe, 8'h00);
    check("R1 reset pa_pu", pa_pu, 8'h00);
    check("R1 reset pb_out", pb_out, 8'h00);
    check("R1 reset pb_pu", pb_pu, 8'h00);
    check("R1 reset rdata", reg_rdata, 8'h00);
    reg_write(A_LATCH, 8'h6C);
    reg_write(B_DIR, 8'h93);
    reg_write(B_PIN, 8'hFF);
    reg_read(A_LATCH, d); check("R1 read A latch", d, 8'h6C);
    reg_read(B_DIR, d);   check("R1 read B dir", d, 8'h93);
    reg_read(A_DIR, d);   check("R1 read A dir", d, 8'h00);
    reg_read(B_LATCH, d); check("R1 B latch untouched by pin write", d, 8'h00);
    reg_read(A_NONE, d);  check("R1 unused field", d, 8'h00);
  endtask

  // R2 and R12: plain port behaviour and pad register latency
  task automatic t_default();
    reg_write(A_DIR, 8'h0F);
    reg_write(A_LATCH, 8'h33);
    // latch changed on this write's edge; pads follow one edge later
    check("R12 pads not yet updated", pa_out, 8'h6C);
    @(negedge clk);
    check("R2 A output enable", pa_oe, 8'h0F);
    check("R2 A driven value", pa_out, 8'h33);
    check("R2 A pull-up", pa_pu, 8'h30);
    @(negedge clk);
    xmem_en = 1'b1; xmem_ale = 1'b1; xmem_addr = 8'hE7;
    #1 check("R12 override before edge", pa_out, 8'h33);
    @(negedge clk);
    check("R12 override after one edge", pa_out, 8'hE7);
    xmem_en = 1'b0; xmem_ale = 1'b0;
    @(negedge clk);
  endtask

  // R3..R10: every strobe/role combination under two register settings
  task automatic t_combos();
    logic [7:0] da, la, db, lb;
    logic [7:0] e_oe, e_out, e_pu;
    logic forced, vov, sig, drv;
    for (int s = 0; s < 2; s++) begin
      da = s ? 8'hF0 : 8'h0F; la = s ? 8'hC3 : 8'h3C;
      db = s ? 8'h0F : 8'hF0; lb = s ? 8'h5A : 8'hA5;
      reg_write(A_DIR, da); reg_write(A_LATCH, la);
      reg_write(B_DIR, db); reg_write(B_LATCH, lb);
      for (int c = 0; c < 32; c++) begin
        @(negedge clk);
        spi_en = c[0]; spi_master = c[1]; xmem_en = c[2];
        xmem_wr = c[3]; xmem_ale = c[4];
        spi_sck_o = ~c[0]; spi_miso_o = c[1] ^ c[3]; spi_mosi_o = ~c[4];
        xmem_addr = 8'h96 ^ 8'(c); xmem_wdata = 8'h41 + 8'(c);
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          forced = spi_en && ((i == 7 || i == 5 || i == 4) ? !spi_master
                                : (i == 6) ? spi_master : 1'b0);
          vov = spi_en && ((i == 7 || i == 5) ? spi_master
                             : (i == 6) ? !spi_master : 1'b0);
          sig = (i == 7) ? spi_sck_o : (i == 6) ? spi_miso_o : spi_mosi_o;
          e_oe[i]  = forced ? 1'b0 : db[i];
          e_pu[i]  = forced ? lb[i] : (!db[i] && lb[i]);
          e_out[i] = vov ? sig : lb[i];
        end
        check("R3 serial clock pin dir", {7'd0, pb_oe[7]}, {7'd0, e_oe[7]});
        check("R4 miso pin dir", {7'd0, pb_oe[6]}, {7'd0, e_oe[6]});
        check("R5 mosi/select pin dir", {6'd0, pb_oe[5:4]}, {6'd0, e_oe[5:4]});
        check("R3,R4,R5 serial pin values", {4'd0, pb_out[7:4]}, {4'd0, e_out[7:4]});
        check("R6 serial pin pull-ups", {4'd0, pb_pu[7:4]}, {4'd0, e_pu[7:4]});
        check("R7 B low pins", {pb_oe[3:0], pb_out[3:0]}, {e_oe[3:0], e_out[3:0]});
        check("R7 B low pull-ups", {4'd0, pb_pu[3:0]}, {4'd0, e_pu[3:0]});
        drv = xmem_wr | xmem_ale;
        e_oe  = xmem_en ? {8{drv}} : da;
        e_out = xmem_en ? (xmem_ale ? xmem_addr : xmem_wr ? xmem_wdata : 8'h00) : la;
        e_pu  = xmem_en ? (la & ~{8{drv}}) : (~da & la);
        check("R8 bus direction", pa_oe, e_oe);
        check("R9 bus value", pa_out, e_out);
        check("R10 bus pull-up", pa_pu, e_pu);
      end
    end
    @(negedge clk);
    spi_en = 0; xmem_en = 0; xmem_wr = 0; xmem_ale = 0;
  endtask

  // R11: pin read through the synchronizer while the bus drives the pins
  task automatic t_pin_sync();
    @(negedge clk);
    xmem_en = 1'b1; xmem_wr = 1'b1; reg_addr = A_PIN;
    pa_in = 8'h00;
    repeat (4) @(negedge clk);
    pa_in = 8'h5E;
    @(negedge clk);
    @(negedge clk);
    check("R11 A pin after two edges", reg_rdata, 8'h00);
    @(negedge clk);
    check("R11 A pin after three edges", reg_rdata, 8'h5E);
    reg_addr = B_PIN; pb_in = 8'hB1;
    repeat (3) @(negedge clk);
    check("R11 B pin read", reg_rdata, 8'hB1);
    xmem_en = 1'b0; xmem_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_regs();
    t_default();
    t_combos();
    t_pin_sync();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #1ms;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule